// File: doc/BRIEF.md
# External SRAM Ring Buffer Controller

This controller turns a single-port synchronous SRAM into one large first-in first-out store. Words come from an on-chip input queue with show-ahead data. The controller writes them at a write pointer and later reads them back at a read pointer, in the order they were written, for a downstream consumer such as a DMA engine. Both pointers wrap at the end of the memory. A fill count tracks how many words the ring holds. With the default parameters the ring is 512K words of 64 bits, which is 4 MB.

Each access has two states. A write is a setup cycle followed by a strobe cycle. A read is a setup cycle followed by a capture cycle. After every access the controller returns to an idle cycle, where it decides what to do next. Writes win that decision whenever input is waiting and the ring is not full. A read is issued only when the ring holds data and the consumer is ready.

All SRAM controls, the address and the write data are registered. The address register loads from a mux that picks between the write pointer and the read pointer, and both pointers are always present. The address therefore cannot glitch while a transfer is in progress. The datapath is split into identical slices. The bus is tri-stated only in the top module.

Top module: `sram_ring_ctrl`

## Requirements
- R1: After reset, chip select, write enable and output enable (all active low) are high. The fill count is 0, empty is 1, full is 0, and out_valid and in_pop are 0.
- R2: When a write is granted in an idle cycle, in_pop is 1 in that cycle. The next cycle is a write setup cycle: chip select low, write enable high, address equal to the write pointer, and the popped word driven on the bus. The cycle after that is the strobe: write enable low, with address and data unchanged. The word is stored at that address. The bus stays driven for one further cycle after the strobe, with chip select high.
- R3: A read is a setup cycle followed by a capture cycle. In both, chip select and output enable are low and write enable is high, and the address is the read pointer. In the cycle after capture, out_valid is 1 for exactly one cycle, and out_data holds the word read. out_data keeps that value until the next read completes.
- R4: Words leave in the same order they entered. Write addresses and read addresses each advance by one per access, starting from 0 after reset.
- R5: When input is waiting, the ring is not full, and a read is also possible, the write is issued first.
- R6: While out_ready is low, no read access starts.
- R7: full is 1 when the fill count equals the depth (2^ADDR_W). While full is 1, in_pop stays low and no write access starts.
- R8: While the fill count is 0, no read access starts, even if out_ready is high.
- R9: A pointer at address 2^ADDR_W−1 moves to address 0 on its next access.
- R10: During the cycles of one access, the address and any write data on the bus do not change.
- R11: The fill count equals the number of completed writes minus the number of completed reads.
- R12: The controller's bus driver and the SRAM output enable are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input queue holds a word |
| in_data | input | DATA_W | Head word of the input queue |
| in_pop | output | 1 | Head word taken this cycle |
| out_ready | input | 1 | Consumer can take a word |
| out_valid | output | 1 | One-cycle pulse: out_data is new |
| out_data | output | DATA_W | Last word read from the ring |
| fill_level | output | ADDR_W+1 | Words held in the ring |
| buf_full | output | 1 | Ring holds 2^ADDR_W words |
| buf_empty | output | 1 | Ring holds no words |
| sram_addr | output | ADDR_W | Registered SRAM word address |
| sram_cs_n | output | 1 | SRAM chip select, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_dq | inout | DATA_W | Bidirectional SRAM data bus |

## Verification
A single isolated write and a single isolated read are traced cycle by cycle. This separates the setup, strobe, hold and capture phases and shows when the bus is released. The consumer is then held off, and afterwards the ring is asked to read with nothing stored. These two cases show that readiness and emptiness each block reads on their own. A burst that arrives while the consumer is already ready shows the write-first ordering. An overfill of more than the depth, followed by a full drain, checks the full stall, both pointer wraps and end-to-end order. Throughout the run, a bus monitor checks each access address against its own pointer model and checks that values stay stable within each access.

// File: rtl/sram_ring_pkg.sv
package sram_ring_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_WR_SETUP   = 3'd1,
    ST_WR_STROBE  = 3'd2,
    ST_RD_SETUP   = 3'd3,
    ST_RD_CAPTURE = 3'd4
  } acc_state_t;

  // Next ring position, wrapping at depth.
  function automatic logic [31:0] wrap_inc(input logic [31:0] p, input logic [31:0] depth);
    return (p == depth - 32'd1) ? 32'd0 : p + 32'd1;
  endfunction

  // Fill count after one cycle of completed writes and reads.
  function automatic logic [31:0] fill_step(input logic [31:0] f, input logic inc, input logic dec);
    logic [31:0] r;
    r = f;
    if (inc && !dec) r = f + 32'd1;
    else if (dec && !inc) r = f - 32'd1;
    return r;
  endfunction

endpackage

// File: rtl/ring_ptrs.sv
module ring_ptrs
  import sram_ring_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_done,
  input  logic              rd_done,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W:0]   fill,
  output logic              full,
  output logic              empty
);
  localparam logic [31:0] DEPTH = 32'd1 << ADDR_W;
  localparam int FW = ADDR_W + 1;

  logic [ADDR_W-1:0] wr_q, rd_q;
  logic [FW-1:0]     fill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      fill_q <= '0;
    end else begin
      if (wr_done) wr_q <= ADDR_W'(wrap_inc(32'(wr_q), DEPTH));
      if (rd_done) rd_q <= ADDR_W'(wrap_inc(32'(rd_q), DEPTH));
      fill_q <= FW'(fill_step(32'(fill_q), wr_done, rd_done));
    end
  end

  assign wr_addr = wr_q;
  assign rd_addr = rd_q;
  assign fill    = fill_q;
  assign full    = (32'(fill_q) == DEPTH);
  assign empty   = (fill_q == '0);

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> !full);
  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> !empty);
  // R9
  wr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && 32'(wr_q) == DEPTH - 32'd1) |=> (wr_q == '0));
  // R9
  rd_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && 32'(rd_q) == DEPTH - 32'd1) |=> (rd_q == '0));
  // R11
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fill_q) <= DEPTH);

endmodule

// File: rtl/access_seq.sv
module access_seq
  import sram_ring_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              out_ready,
  input  logic              full,
  input  logic              empty,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              in_pop,
  output logic              wr_done,
  output logic              rd_done,
  output logic              out_valid,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              cs_n,
  output logic              we_n,
  output logic              oe_n,
  output logic              drv_en
);
  acc_state_t st, nst;
  logic grant_wr, grant_rd;
  logic [ADDR_W-1:0] addr_q;
  logic cs_n_q, we_n_q, oe_n_q, drv_q, ov_q;

  assign grant_wr = (st == ST_IDLE) && in_valid && !full;
  assign grant_rd = (st == ST_IDLE) && !grant_wr && !empty && out_ready;

  always_comb begin
    nst = st;
    case (st)
      ST_IDLE:       if (grant_wr) nst = ST_WR_SETUP;
                     else if (grant_rd) nst = ST_RD_SETUP;
      ST_WR_SETUP:   nst = ST_WR_STROBE;
      ST_WR_STROBE:  nst = ST_IDLE;
      ST_RD_SETUP:   nst = ST_RD_CAPTURE;
      ST_RD_CAPTURE: nst = ST_IDLE;
      default:       nst = ST_IDLE;
    endcase
  end

  // All pin values come straight from flops, loaded from the next state.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      addr_q <= '0;
      cs_n_q <= 1'b1;
      we_n_q <= 1'b1;
      oe_n_q <= 1'b1;
      drv_q  <= 1'b0;
      ov_q   <= 1'b0;
    end else begin
      st     <= nst;
      // The address mux picks between two pointer values that are always present.
      if (grant_wr)      addr_q <= wr_addr;
      else if (grant_rd) addr_q <= rd_addr;
      cs_n_q <= (nst == ST_IDLE);
      we_n_q <= (nst != ST_WR_STROBE);
      oe_n_q <= !(nst == ST_RD_SETUP || nst == ST_RD_CAPTURE);
      drv_q  <= (nst == ST_WR_SETUP) || (nst == ST_WR_STROBE) || (st == ST_WR_STROBE);
      ov_q   <= (st == ST_RD_CAPTURE);
    end
  end

  assign in_pop    = grant_wr;
  assign wr_done   = (st == ST_WR_STROBE);
  assign rd_done   = (st == ST_RD_CAPTURE);
  assign out_valid = ov_q;
  assign sram_addr = addr_q;
  assign cs_n      = cs_n_q;
  assign we_n      = we_n_q;
  assign oe_n      = oe_n_q;
  assign drv_en    = drv_q;

  // R2
  we_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!cs_n && drv_en && $past(!cs_n) && $past(we_n)));
  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> $stable(sram_addr));
  // R12
  bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_en && !oe_n));
  // R7
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !in_pop);
  // R8 and R6
  rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && (empty || !out_ready)) |=> oe_n);
  // R5
  wr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && in_valid && !full) |=> (!cs_n && oe_n));
  // R3
  ov_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

endmodule

// File: rtl/data_slice.sv
module data_slice #(
  parameter int SW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          cap,
  input  logic [SW-1:0] din,
  input  logic [SW-1:0] dq_in,
  output logic [SW-1:0] wq,
  output logic [SW-1:0] rq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wq <= '0;
      rq <= '0;
    end else begin
      if (load) wq <= din;
      if (cap)  rq <= dq_in;
    end
  end
endmodule

// File: rtl/sram_ring_ctrl.sv
module sram_ring_ctrl #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 19,
  parameter int SLICES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_pop,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [ADDR_W:0]   fill_level,
  output logic              buf_full,
  output logic              buf_empty,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_cs_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  inout  wire  [DATA_W-1:0] sram_dq
);
  localparam int SW = DATA_W / SLICES;

  logic              wr_done, rd_done, drv_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wdata, rdata;

  ring_ptrs #(.ADDR_W(ADDR_W)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .wr_done(wr_done), .rd_done(rd_done),
    .wr_addr(wr_addr), .rd_addr(rd_addr), .fill(fill_level),
    .full(buf_full), .empty(buf_empty)
  );

  access_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .full(buf_full), .empty(buf_empty), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .in_pop(in_pop), .wr_done(wr_done), .rd_done(rd_done), .out_valid(out_valid),
    .sram_addr(sram_addr), .cs_n(sram_cs_n), .we_n(sram_we_n), .oe_n(sram_oe_n),
    .drv_en(drv_en)
  );

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    data_slice #(.SW(SW)) u_slice (
      .clk(clk), .rst_n(rst_n), .load(in_pop), .cap(rd_done),
      .din(in_data[s*SW +: SW]), .dq_in(sram_dq[s*SW +: SW]),
      .wq(wdata[s*SW +: SW]), .rq(rdata[s*SW +: SW])
    );
  end

  // The only tri-state driver in the design sits here, at the top.
  assign sram_dq  = drv_en ? wdata : {DATA_W{1'bz}};
  assign out_data = rdata;

  // R10
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_cs_n && $past(!sram_cs_n)) |-> $stable(wdata));
  // R3
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_done) |-> $stable(out_data));

endmodule

// File: tb/sram_ring_ctrl_tb.sv
module sram_ring_ctrl_tb;
  localparam int DW = 64;
  localparam int AW = 4;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_pop, out_ready = 1'b0, out_valid;
  logic [DW-1:0] out_data;
  logic [AW:0] fill_level;
  logic buf_full, buf_empty;
  logic [AW-1:0] sram_addr;
  logic sram_cs_n, sram_we_n, sram_oe_n;
  wire  [DW-1:0] sram_dq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sram_ring_ctrl #(.DATA_W(DW), .ADDR_W(AW), .SLICES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_pop(in_pop),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .fill_level(fill_level), .buf_full(buf_full), .buf_empty(buf_empty),
    .sram_addr(sram_addr), .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .sram_dq(sram_dq)
  );

  // SRAM model
  logic [DW-1:0] mem [DEPTH];
  assign sram_dq = (!sram_cs_n && !sram_oe_n && sram_we_n) ? mem[sram_addr] : {DW{1'bz}};
  always @(posedge clk) if (!sram_cs_n && !sram_we_n) mem[sram_addr] <= sram_dq;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Input queue feeder with show-ahead data
  logic [DW-1:0] src[$];
  bit pop_pend = 0;
  always @(negedge clk) begin
    if (pop_pend && src.size() > 0) void'(src.pop_front());
    pop_pend = 0;
    in_valid = (src.size() != 0);
    if (src.size() != 0) in_data = src[0];
    #1 pop_pend = in_pop;
  end

  // Sink, event log and bus monitor
  logic [DW-1:0] sink[$];
  byte evlog[$];
  logic [AW-1:0] exp_wa = '0, exp_ra = '0;
  int wr_cnt = 0;
  logic prev_cs_n = 1'b1, prev_oe_n = 1'b1;
  logic [AW-1:0] prev_addr = '0;
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (out_valid) begin sink.push_back(out_data); evlog.push_back("R"); end
      if (!sram_cs_n && !sram_we_n) begin
        evlog.push_back("W");
        chk(sram_addr == exp_wa, "R9", "write address", DW'(sram_addr), DW'(exp_wa));
        exp_wa = exp_wa + 1'b1;
        wr_cnt++;
      end
      if (!sram_oe_n && prev_oe_n) begin
        chk(sram_addr == exp_ra, "R4", "read address", DW'(sram_addr), DW'(exp_ra));
        exp_ra = exp_ra + 1'b1;
      end
      if (!sram_cs_n && !prev_cs_n)
        chk(sram_addr == prev_addr, "R10", "address stable in access", DW'(sram_addr), DW'(prev_addr));
    end
    prev_cs_n = sram_cs_n;
    prev_oe_n = sram_oe_n;
    prev_addr = sram_addr;
  end

  task automatic step();
    @(negedge clk); #2;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) step();
    chk(sram_cs_n && sram_we_n && sram_oe_n, "R1", "controls idle", DW'({sram_cs_n, sram_we_n, sram_oe_n}), DW'(3'b111));
    chk(fill_level == 0 && buf_empty && !buf_full, "R1", "flags", DW'({fill_level, buf_empty, buf_full}), DW'(2'b10));
    chk(!out_valid && !in_pop, "R1", "valid/pop low", DW'({out_valid, in_pop}), '0);
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_write_seq(input logic [DW-1:0] d);
    logic [AW-1:0] a = exp_wa;
    logic [AW:0] f0 = fill_level;
    src.push_back(d);
    step();
    chk(in_pop && sram_cs_n, "R2", "pop in grant cycle", DW'({in_pop, sram_cs_n}), DW'(2'b11));
    step();
    chk(!sram_cs_n && sram_we_n && sram_oe_n, "R2", "setup controls", DW'({sram_cs_n, sram_we_n, sram_oe_n}), DW'(3'b011));
    chk(sram_addr == a, "R2", "setup address", DW'(sram_addr), DW'(a));
    chk(sram_dq == d, "R2", "setup data", sram_dq, d);
    step();
    chk(!sram_cs_n && !sram_we_n, "R2", "strobe controls", DW'({sram_cs_n, sram_we_n}), '0);
    chk(sram_dq == d && sram_addr == a, "R10", "strobe data stable", sram_dq, d);
    step();
    chk(sram_cs_n && sram_oe_n && sram_dq == d, "R12", "hold cycle drives, oe high", sram_dq, d);
    chk(mem[a] == d, "R2", "stored word", mem[a], d);
    chk(fill_level == f0 + 1, "R11", "fill after write", DW'(fill_level), DW'(f0 + 1));
  endtask

  task automatic t_read_seq(input logic [DW-1:0] d);
    logic [AW-1:0] a = exp_ra;
    out_ready = 1'b1;
    step();
    chk(!sram_cs_n && !sram_oe_n && sram_we_n, "R3", "read setup controls", DW'({sram_cs_n, sram_oe_n, sram_we_n}), DW'(3'b001));
    chk(sram_addr == a, "R3", "read address", DW'(sram_addr), DW'(a));
    out_ready = 1'b0;
    step();
    chk(!sram_cs_n && !sram_oe_n && !out_valid, "R3", "capture cycle", DW'({sram_cs_n, sram_oe_n, out_valid}), '0);
    step();
    chk(out_valid && out_data == d, "R3", "returned word", out_data, d);
    chk(buf_empty && fill_level == 0, "R11", "empty after read", DW'(fill_level), '0);
    step();
    chk(!out_valid && out_data == d, "R3", "pulse ends, data holds", DW'(out_valid), '0);
  endtask

  task automatic t_empty();
    bit seen = 0;
    out_ready = 1'b1;
    repeat (6) begin step(); if (!sram_cs_n) seen = 1; end
    chk(!seen, "R8", "no access when empty", DW'(seen), '0);
    out_ready = 1'b0;
  endtask

  task automatic t_not_ready_then_order();
    logic [DW-1:0] exp[$];
    bit rd_seen = 0;
    sink.delete();
    for (int i = 0; i < 3; i++) begin
      exp.push_back({32'hC0DE_0000 + 32'(i), 32'h1234_5670 ^ 32'(i)});
      src.push_back(exp[i]);
    end
    repeat (20) begin step(); if (!sram_oe_n) rd_seen = 1; end
    chk(!rd_seen && sink.size() == 0, "R6", "no read while not ready", DW'(rd_seen), '0);
    chk(fill_level == 3, "R11", "fill holds three", DW'(fill_level), DW'(3));
    out_ready = 1'b1;
    for (int k = 0; k < 40 && sink.size() < 3; k++) step();
    out_ready = 1'b0;
    chk(sink.size() == 3, "R4", "drained count", DW'(sink.size()), DW'(3));
    for (int i = 0; i < 3 && i < sink.size(); i++)
      chk(sink[i] == exp[i], "R4", "order", sink[i], exp[i]);
  endtask

  task automatic t_priority();
    string got = "";
    evlog.delete();
    out_ready = 1'b1;
    step();
    for (int i = 0; i < 4; i++) src.push_back(64'hBEEF_0000_0000_0000 + 64'(i));
    for (int k = 0; k < 60 && evlog.size() < 8; k++) step();
    out_ready = 1'b0;
    foreach (evlog[i]) got = {got, string'(evlog[i])};
    chk(got == "WWWWRRRR", "R5", "writes before reads", DW'(evlog.size()), DW'(8));
    if (got != "WWWWRRRR") $display("FAIL R5 sequence %s expected WWWWRRRR", got);
  endtask

  task automatic t_full_wrap();
    logic [DW-1:0] exp[$];
    bit wr_seen = 0;
    int w0 = wr_cnt;
    sink.delete();
    for (int i = 0; i < DEPTH + 2; i++) begin
      exp.push_back({32'hF00D_0000 + 32'(i), 32'(i) * 32'd7});
      src.push_back(exp[i]);
    end
    for (int k = 0; k < 200 && fill_level != DEPTH; k++) step();
    chk(buf_full && fill_level == DEPTH, "R7", "full at depth", DW'(fill_level), DW'(DEPTH));
    repeat (10) begin step(); if (in_pop || !sram_cs_n) wr_seen = 1; end
    chk(!wr_seen && in_valid && fill_level == DEPTH, "R7", "writes held off while full", DW'(wr_seen), '0);
    out_ready = 1'b1;
    for (int k = 0; k < 600 && (sink.size() < DEPTH + 2 || fill_level != 0); k++) step();
    out_ready = 1'b0;
    chk(sink.size() == DEPTH + 2, "R4", "overfill drain count", DW'(sink.size()), DW'(DEPTH + 2));
    for (int i = 0; i < DEPTH + 2 && i < sink.size(); i++)
      chk(sink[i] == exp[i], "R9", "order across wrap", sink[i], exp[i]);
    chk(wr_cnt - w0 == DEPTH + 2, "R9", "writes across wrap", DW'(wr_cnt - w0), DW'(DEPTH + 2));
    chk(buf_empty, "R11", "empty after drain", DW'(fill_level), '0);
  endtask

  initial begin
    t_reset();
    t_write_seq(64'hA5A5_1111_5A5A_2222);
    t_read_seq(64'hA5A5_1111_5A5A_2222);
    t_empty();
    t_not_ready_then_order();
    t_priority();
    t_full_wrap();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule